// File: doc/BRIEF.md
# Presettable Two-Section Ripple Counter

This block is a 4-bit counter made of two sections, each with its own count input. Bit 0 is a divide-by-two stage that advances on falling edges of `cp0`. Bits 3..1 form a second stage that advances on falling edges of `cp1`. A parameter picks that stage's modulus: five in the decade variant and eight in the binary variant. The block leaves both count inputs open. The user wires one section's output to the other section's count input to get the counting mode wanted.

If `q[0]` feeds `cp1`, the decade variant counts 0 to 9 in 8-4-2-1 BCD and the binary variant counts modulo 16. If `q[3]` feeds `cp0` in the decade variant, the count is bi-quinary and `q[0]` is a square wave with a 50% duty cycle and a period of ten input falls. An active-low clear overrides everything else. An active-low load overrides counting and makes the outputs track the data inputs like a transparent latch.

Both count inputs are ordinary levels sampled on the system clock `clk`. All state changes take place on the rising edge of `clk`, and every result appears one system clock after its cause.

Top module: `twosec_counter`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, `q` becomes 4'b0000.
- R2: While `clear_n` is low at a rising `clk` edge, `q` becomes 4'b0000 on that edge, whatever `load_n`, `d`, `cp0` and `cp1` are doing; count-input falls that occur during clear are dropped.
- R3: With `clear_n` high and `load_n` low, `q` takes the value of `d` on every rising `clk` edge (transparent-latch behaviour); count-input falls in this state do not change `q`.
- R4: After `load_n` returns high, `q` keeps the last loaded value and ignores `d`; the next count-input falls advance from that value.
- R5: A fall on `cp0` (sampled high on one `clk` edge, low on the next) inverts `q[0]` on the edge that first samples the low level.
- R6: In the decade variant, each `cp1` fall steps `q[3:1]` through 000, 001, 010, 011, 100 and then back to 000.
- R7: In the decade variant, when `q[3:1]` holds an unused code (101, 110 or 111), the next `cp1` fall sets it to 000.
- R8: In the binary variant, each `cp1` fall increments `q[3:1]` in plain binary from 000 to 111, wrapping to 000.
- R9: Decade variant with `q[0]` wired to `cp1`: after n falls on `cp0`, the settled `q` equals n mod 10, read as a binary number with `q[3]` as the most significant bit.
- R10: Decade variant with `q[3]` wired to `cp0`: after n falls on `cp1`, the settled `q[3:1]` equals n mod 5 and `q[0]` equals (n div 5) mod 2. Over any ten consecutive falls, `q[0]` is high after exactly five of them.
- R11: Binary variant with `q[0]` wired to `cp1`: after n falls on `cp0`, the settled `q` equals n mod 16.
- R12: A rising edge or a steady level on a count input leaves `q` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low system reset |
| clear_n | input | 1 | Active-low master clear, highest functional priority |
| load_n | input | 1 | Active-low parallel load; `q` follows `d` while low |
| cp0 | input | 1 | Count input of the divide-by-two section (bit 0) |
| cp1 | input | 1 | Count input of the upper section (bits 3..1) |
| d | input | WIDTH (4) | Parallel data loaded while `load_n` is low |
| q | output | WIDTH (4) | Counter state; `q[0]` is the divide-by-two stage |

## Verification
The assertions assume that `cp0` and `cp1` are already synchronous to `clk`, that each level is held for at least one system clock, and that a feedback path from `q` to a count input takes one registered hop. The bench drives every control and count input only at falling `clk` edges and keeps each count-input phase several cycles long. It changes the wiring between sections only after a clear, with the driven count inputs low, so that a rewire cannot create a false fall. Results are compared only after the ripple through a chained section has settled, which takes two system clocks after the input fall.

// File: rtl/twosec_pkg.sv
// Package: shared action encoding and priority resolution for the counter
// stages. Assumes clear_n and load_n are active-low and synchronous to clk.
package twosec_pkg;

    // What a stage does on the coming clock edge.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_STEP  = 2'd3
    } stage_act_e;

    // Resolve priority: clear over load over a detected count fall.
    function automatic stage_act_e pick_act(input logic clear_n,
                                            input logic load_n,
                                            input logic fall);
        stage_act_e a;
        if (!clear_n)      a = ACT_CLEAR;
        else if (!load_n)  a = ACT_LOAD;
        else if (fall)     a = ACT_STEP;
        else               a = ACT_HOLD;
        return a;
    endfunction

endpackage

// File: rtl/fall_detect.sv
// Module: fall_detect
// Flags a high-to-low transition of a level input that is already
// synchronous to clk. Keeps one registered copy of the previous level;
// the flag is combinational from that copy and the current level, so a
// stage using it acts on the first clk edge that samples the low level.
module fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);

    logic prev_lvl;

    // Remember the level seen at the last clk edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_lvl <= 1'b0;
        else        prev_lvl <= lvl;
    end

    // A fall is "was high, now low".
    assign fall = prev_lvl & ~lvl;

    // A fall consumes the high level, so two falls cannot be back to back (R5).
    assert_no_double_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/div2_stage.sv
// Module: div2_stage
// Bit 0 of the counter: a divide-by-two stage. Clears, loads from its
// data bit, or toggles on a detected fall of its count input, with the
// priority fixed by twosec_pkg::pick_act.
module div2_stage
    import twosec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear_n,
    input  logic load_n,
    input  logic fall,
    input  logic d_bit,
    output logic q_bit
);

    stage_act_e act;

    // Choose this cycle's action.
    assign act = pick_act(clear_n, load_n, fall);

    // Update the stage bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_bit <= 1'b0;
        end else begin
            case (act)
                ACT_CLEAR: q_bit <= 1'b0;
                ACT_LOAD:  q_bit <= d_bit;
                ACT_STEP:  q_bit <= ~q_bit;
                default:   q_bit <= q_bit;
            endcase
        end
    end

    // Each accepted fall inverts the bit (R5).
    assert_toggle_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && load_n && fall) |=> (q_bit != $past(q_bit)));

    // With no fall, no load and no clear, the bit is held (R12).
    assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && load_n && !fall) |=> $stable(q_bit));

endmodule

// File: rtl/upper_stage.sv
// Module: upper_stage
// Bits 3..1 of the counter. DECADE=1 builds a divide-by-five sequence
// (0..4, unused codes return to 0); DECADE=0 builds a plain binary
// divide-by-2**HI_W counter. Same clear/load/step priority as bit 0.
module upper_stage
    import twosec_pkg::*;
#(
    parameter bit DECADE = 1'b1,
    parameter int HI_W   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_n,
    input  logic            load_n,
    input  logic            fall,
    input  logic [HI_W-1:0] d_hi,
    output logic [HI_W-1:0] q_hi
);

    localparam int          MODULUS = DECADE ? 5 : (1 << HI_W);
    localparam logic [HI_W-1:0] LAST = HI_W'(MODULUS - 1);

    stage_act_e      act;
    logic [HI_W-1:0] q_next;

    // Choose this cycle's action.
    assign act = pick_act(clear_n, load_n, fall);

    generate
        if (DECADE) begin : g_mod5
            // Step the short sequence; anything at or past the last code wraps.
            always_comb begin
                if (q_hi >= LAST) q_next = '0;
                else              q_next = q_hi + 1'b1;
            end

            // After a step the code is a valid divide-by-five state (R6, R7).
            assert_valid_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (clear_n && load_n && fall) |=> (q_hi <= LAST));
        end else begin : g_bin
            // Plain binary increment with natural wrap.
            always_comb begin
                q_next = q_hi + 1'b1;
            end

            // Each step adds exactly one modulo 2**HI_W (R8).
            assert_binary_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (clear_n && load_n && fall) |=> (q_hi == HI_W'($past(q_hi) + 1)));
        end
    endgenerate

    // Update the upper stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_hi <= '0;
        end else begin
            case (act)
                ACT_CLEAR: q_hi <= '0;
                ACT_LOAD:  q_hi <= d_hi;
                ACT_STEP:  q_hi <= q_next;
                default:   q_hi <= q_hi;
            endcase
        end
    end

    // Idle cycles leave the stage untouched (R12).
    assert_hi_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && load_n && !fall) |=> $stable(q_hi));

endmodule

// File: rtl/twosec_counter.sv
// Module: twosec_counter (top)
// Presettable counter in two independently clocked sections. cp0 and cp1
// are levels synchronous to clk; falls are detected in the clk domain.
// Chaining between sections is done outside the block by wiring q bits
// back to cp0/cp1.
module twosec_counter #(
    parameter bit DECADE = 1'b1,
    parameter int WIDTH  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_n,
    input  logic             load_n,
    input  logic             cp0,
    input  logic             cp1,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam int HI_W = WIDTH - 1;

    logic fall0;
    logic fall1;

    // Falling-edge detectors, one per count input.
    fall_detect u_fall0 (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (cp0),
        .fall  (fall0)
    );

    fall_detect u_fall1 (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (cp1),
        .fall  (fall1)
    );

    // Bit 0: divide-by-two.
    div2_stage u_lo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_n (clear_n),
        .load_n  (load_n),
        .fall    (fall0),
        .d_bit   (d[0]),
        .q_bit   (q[0])
    );

    // Bits WIDTH-1..1: divide-by-five or binary.
    upper_stage #(
        .DECADE (DECADE),
        .HI_W   (HI_W)
    ) u_hi (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_n (clear_n),
        .load_n  (load_n),
        .fall    (fall1),
        .d_hi    (d[WIDTH-1:1]),
        .q_hi    (q[WIDTH-1:1])
    );

    // Clear wins over every other input (R2).
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n |=> (q == '0));

    // Load without clear copies the data inputs (R3).
    assert_load_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && !load_n) |=> (q == $past(d)));

endmodule

// File: tb/twosec_counter_bench.sv
module twosec_counter_bench;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, clear_n, load_n;
    logic [3:0] d;
    logic       dc0_drv, dc1_drv, bc0_drv, bc1_drv;
    int         dmode;   // 0 direct, 1 BCD chain, 2 bi-quinary chain
    int         bmode;   // 0 direct, 1 modulo-16 chain
    logic [3:0] q_dec, q_bin;
    logic       cp0_dec, cp1_dec, cp0_bin, cp1_bin;

    assign cp0_dec = (dmode == 2) ? q_dec[3] : dc0_drv;
    assign cp1_dec = (dmode == 1) ? q_dec[0] : dc1_drv;
    assign cp0_bin = bc0_drv;
    assign cp1_bin = (bmode == 1) ? q_bin[0] : bc1_drv;

    twosec_counter #(.DECADE(1'b1), .WIDTH(4)) u_twosec_counter (
        .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .load_n(load_n),
        .cp0(cp0_dec), .cp1(cp1_dec), .d(d), .q(q_dec));

    twosec_counter #(.DECADE(1'b0), .WIDTH(4)) u_twosec_counter_bin (
        .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .load_n(load_n),
        .cp0(cp0_bin), .cp1(cp1_bin), .d(d), .q(q_bin));

    typedef struct {
        logic [3:0] exp;
        logic       bin;
        string      tag;
    } item_t;

    item_t sb_q[$];
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Driver side: queue an expected value for the monitor.
    task automatic expect_q(input logic bin, input logic [3:0] e, input string tag);
        sb_q.push_back('{exp: e, bin: bin, tag: tag});
    endtask

    // One full pulse on a driven count input, then time to settle a chain.
    task automatic pulse(input int which);
        case (which)
            0: dc0_drv = 1'b1;
            1: dc1_drv = 1'b1;
            2: bc0_drv = 1'b1;
            default: bc1_drv = 1'b1;
        endcase
        repeat (2) @(negedge clk);
        case (which)
            0: dc0_drv = 1'b0;
            1: dc1_drv = 1'b0;
            2: bc0_drv = 1'b0;
            default: bc1_drv = 1'b0;
        endcase
        repeat (4) @(negedge clk);
    endtask

    task automatic do_clear();
        clear_n = 1'b0;
        @(negedge clk);
        clear_n = 1'b1;
        @(negedge clk);
    endtask

    // Monitor: compare queued expectations just after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [3:0] act;
                it  = sb_q.pop_front();
                act = it.bin ? q_bin : q_dec;
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s: %s q=%b expected %b", it.tag,
                             it.bin ? "binary" : "decade", act, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int ones;
        rst_n = 1'b0; clear_n = 1'b1; load_n = 1'b1; d = 4'b0000;
        dc0_drv = 0; dc1_drv = 0; bc0_drv = 0; bc1_drv = 0;
        dmode = 0; bmode = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_q(1'b0, 4'b0000, "R1 reset decade");
        expect_q(1'b1, 4'b0000, "R1 reset binary");

        // R5: divide-by-two toggling
        pulse(0); expect_q(1'b0, 4'b0001, "R5 first cp0 fall");
        pulse(0); expect_q(1'b0, 4'b0000, "R5 second cp0 fall");

        // R12: rising edge and steady high do nothing
        dc0_drv = 1'b1;
        repeat (3) @(negedge clk);
        expect_q(1'b0, 4'b0000, "R12 rising/steady cp0");
        dc0_drv = 1'b0;
        repeat (2) @(negedge clk);
        expect_q(1'b0, 4'b0001, "R5 fall after long high");

        // R6: divide-by-five sequence
        do_clear();
        for (int n = 1; n <= 6; n++) begin
            pulse(1);
            expect_q(1'b0, 4'((n % 5) << 1), "R6 div5 step");
        end

        // R7: unused codes return to zero
        load_n = 1'b0; d = 4'b1010; @(negedge clk); load_n = 1'b1; @(negedge clk);
        pulse(1); expect_q(1'b0, 4'b0000, "R7 code 101");
        load_n = 1'b0; d = 4'b1100; @(negedge clk); load_n = 1'b1; @(negedge clk);
        pulse(1); expect_q(1'b0, 4'b0000, "R7 code 110");
        load_n = 1'b0; d = 4'b1111; @(negedge clk); load_n = 1'b1; @(negedge clk);
        pulse(1); expect_q(1'b0, 4'b0001, "R7 code 111");

        // R3: transparent load, overrides counting
        load_n = 1'b0; d = 4'b0011;
        @(negedge clk); expect_q(1'b0, 4'b0011, "R3 load follows d");
        d = 4'b1001;
        @(negedge clk); expect_q(1'b0, 4'b1001, "R3 load tracks new d");
        pulse(0); expect_q(1'b0, 4'b1001, "R3 cp0 fall ignored during load");
        pulse(1); expect_q(1'b0, 4'b1001, "R3 cp1 fall ignored during load");

        // R4: hold after release, resume from loaded value
        load_n = 1'b1; d = 4'b0110;
        @(negedge clk); expect_q(1'b0, 4'b1001, "R4 hold after load release");
        pulse(0); expect_q(1'b0, 4'b1000, "R4 resume bit0");
        pulse(1); expect_q(1'b0, 4'b0000, "R4 resume upper from 100");

        // R2: clear beats load and counting
        load_n = 1'b1; d = 4'b0101; @(negedge clk);
        load_n = 1'b0; @(negedge clk); load_n = 1'b1; @(negedge clk);
        expect_q(1'b0, 4'b0101, "R3 preload before clear");
        clear_n = 1'b0; load_n = 1'b0; d = 4'b1111; dc0_drv = 1'b1;
        @(negedge clk); expect_q(1'b0, 4'b0000, "R2 clear over load");
        dc0_drv = 1'b0;
        @(negedge clk); expect_q(1'b0, 4'b0000, "R2 clear over cp0 fall");
        clear_n = 1'b1; load_n = 1'b1;
        repeat (2) @(negedge clk);
        expect_q(1'b0, 4'b0000, "R2 no residual count after clear");

        // R9: BCD chaining
        do_clear();
        dmode = 1;
        for (int n = 1; n <= 12; n++) begin
            pulse(0);
            expect_q(1'b0, 4'(n % 10), "R9 BCD count");
        end

        // R10: bi-quinary chaining
        dmode = 0;
        do_clear();
        dmode = 2;
        ones = 0;
        for (int n = 1; n <= 20; n++) begin
            pulse(1);
            expect_q(1'b0, 4'(((n % 5) << 1) | ((n / 5) % 2)), "R10 bi-quinary count");
            if (n > 10) ones += int'(q_dec[0]);
        end
        total++;
        if (ones != 5) begin
            bad++;
            $display("FAIL R10 duty: q0 high count=%0d expected 5", ones);
        end

        // R8: binary upper section alone
        dmode = 0;
        do_clear();
        for (int n = 1; n <= 9; n++) begin
            pulse(3);
            expect_q(1'b1, 4'((n % 8) << 1), "R8 binary upper step");
        end

        // R11: modulo-16 chaining
        do_clear();
        bmode = 1;
        for (int n = 1; n <= 18; n++) begin
            pulse(2);
            expect_q(1'b1, 4'(n % 16), "R11 modulo-16 count");
        end

        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule